// File: doc/BRIEF.md
# Frame Address Bit-Order Converter

This block is a byte-wide streaming stage for a token-ring frame path. It works on either the transmit or the receive side. It rewrites the destination and source address fields of every frame so that each address byte changes between the on-wire order, where the least significant bit goes first, and canonical order. It does this by mirroring the bits inside each address byte. The order of the bytes is not changed.

The stage finds the address fields by counting accepted bytes from the frame-control byte, which is the first byte after start-of-frame. One bit of that byte selects between long addresses of six bytes and short addresses of two bytes. The frame-control byte, every byte after the source address, and any byte outside a frame go through unchanged. The stream can serve several logical channels, and each channel has its own enable for the conversion. The output stream keeps the input framing exactly and arrives one clock later.

Top module: `fa_addr_bitswap`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_sof`, `out_eof` and `out_data` are all zero.
- R2: On each clock, `out_valid`, `out_sof` and `out_eof` equal the values that `in_valid`, `in_valid & in_sof` and `in_valid & in_eof` had one clock earlier.
- R3: The frame-control byte, which is the valid byte with `in_sof` high, comes out unchanged.
- R4: When frame-control bit 6 is 1 and conversion is on, the 12 accepted bytes after frame control each come out with their bits mirrored, so output bit i equals input bit 7-i. For example, address 08-00-17-C2-A1-03 becomes 10-00-E8-43-85-C0.
- R5: When frame-control bit 6 is 0 and conversion is on, only the 4 accepted bytes after frame control are mirrored.
- R6: Bytes after the last source-address byte come out unchanged.
- R7: The enable for a frame is bit `in_chan` of `chan_swap_en`. When that bit is 0, every byte of the frame comes out unchanged.
- R8: The channel and enable are sampled on the start-of-frame byte. Changes to them later in the frame have no effect on that frame.
- R9: Cycles with `in_valid` low do not advance the byte position. Valid bytes outside a frame come out unchanged.
- R10: A frame that ends inside its address fields stops the conversion, and the next start-of-frame begins counting again from frame control.
- R11: A start-of-frame that arrives while a frame is still open begins a new frame at that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_chan | input | CH_W (2) | Channel that the current frame belongs to |
| chan_swap_en | input | NUM_CH (4) | Conversion enable, one bit per channel |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first byte of a frame (frame control) |
| in_eof | input | 1 | Input byte is the last byte of a frame |
| in_data | input | DATA_W (8) | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Output start-of-frame marker |
| out_eof | output | 1 | Output end-of-frame marker |
| out_data | output | DATA_W (8) | Output byte, with address bytes mirrored when conversion is on |

## Verification
Every result of this block is due exactly one clock after the byte that causes it: the mirrored or unchanged data, and the delayed valid and framing markers. The bench drives each byte on a falling edge and samples the outputs on the next falling edge, half a period after the rising edge that registered them. At that point it compares all four outputs with the value its model predicted for the byte driven one step earlier. The bench's queue of output bytes is keyed to the valid beats only, so the fixed address example is checked at byte positions and not at cycle numbers, even when idle gaps are inserted.

// File: rtl/fabr_pkg.sv
package fabr_pkg;

   localparam int BYTE_W = 8;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef struct packed {
      logic  valid;
      logic  sof;
      logic  eof;
      byte_t data;
   } beat_t;

   function automatic byte_t rev_byte(byte_t b);
      byte_t r;
      for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
      return r;
   endfunction

endpackage

// File: rtl/fabr_byte_rev.sv
module fabr_byte_rev #(
   parameter int W = 8
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign dout[i] = din[W-1-i];
   end
endmodule

// File: rtl/fabr_frame_tracker.sv
module fabr_frame_tracker #(
   parameter int NUM_CH      = 4,
   parameter int CH_W        = 2,
   parameter int LONG_BYTES  = 6,
   parameter int SHORT_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_W-1:0]   in_chan,
   input  logic [NUM_CH-1:0] chan_swap_en,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic              fc_long,
   output logic              swap_now
);
   localparam int LONG_SPAN  = 2 * LONG_BYTES;
   localparam int SHORT_SPAN = 2 * SHORT_BYTES;
   localparam int CNT_W      = $clog2(LONG_SPAN + 2);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] span;
   logic             active_q;
   logic             long_q;
   logic             en_q;
   logic             sel_en;

   if (NUM_CH == 1) begin : g_single
      assign sel_en = chan_swap_en[0];
   end else begin : g_multi
      assign sel_en = chan_swap_en[in_chan];
   end

   assign span     = long_q ? CNT_W'(LONG_SPAN) : CNT_W'(SHORT_SPAN);
   assign swap_now = in_valid && !in_sof && active_q && en_q && (cnt_q <= span);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
         long_q   <= 1'b0;
         en_q     <= 1'b0;
      end else if (in_valid) begin
         if (in_sof) begin
            active_q <= !in_eof;
            cnt_q    <= CNT_W'(1);
            long_q   <= fc_long;
            en_q     <= sel_en;
         end else if (active_q) begin
            if (cnt_q <= span) cnt_q <= cnt_q + CNT_W'(1);
            if (in_eof) active_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fabr_out_stage.sv
module fabr_out_stage (
   input  logic            clk,
   input  logic            rst_n,
   input  fabr_pkg::beat_t d_in,
   output fabr_pkg::beat_t q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d_in;
   end
endmodule

// File: rtl/fa_addr_bitswap.sv
module fa_addr_bitswap #(
   parameter int DATA_W      = 8,
   parameter int NUM_CH      = 4,
   parameter int LEN_BIT     = 6,
   parameter int LONG_BYTES  = 6,
   parameter int SHORT_BYTES = 2,
   localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_W-1:0]   in_chan,
   input  logic [NUM_CH-1:0] chan_swap_en,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic              out_sof,
   output logic              out_eof,
   output logic [DATA_W-1:0] out_data
);
   import fabr_pkg::*;

   if (DATA_W != BYTE_W) begin : g_bad_width
      $error("fa_addr_bitswap: DATA_W must equal the package byte width");
   end
   if (LEN_BIT >= DATA_W) begin : g_bad_lenbit
      $error("fa_addr_bitswap: LEN_BIT outside the byte");
   end
   if (SHORT_BYTES < 1 || SHORT_BYTES >= LONG_BYTES) begin : g_bad_span
      $error("fa_addr_bitswap: need 1 <= SHORT_BYTES < LONG_BYTES");
   end
   if (NUM_CH < 1 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("fa_addr_bitswap: NUM_CH must be a power of two");
   end

   logic  swap_now;
   byte_t rev_data;
   beat_t nxt;
   beat_t cur;

   fabr_frame_tracker #(
      .NUM_CH(NUM_CH), .CH_W(CH_W),
      .LONG_BYTES(LONG_BYTES), .SHORT_BYTES(SHORT_BYTES)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .in_chan(in_chan), .chan_swap_en(chan_swap_en),
      .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
      .fc_long(in_data[LEN_BIT]), .swap_now(swap_now)
   );

   fabr_byte_rev #(.W(BYTE_W)) u_rev (.din(in_data), .dout(rev_data));

   always_comb begin
      nxt.valid = in_valid;
      nxt.sof   = in_valid & in_sof;
      nxt.eof   = in_valid & in_eof;
      nxt.data  = swap_now ? rev_data : in_data;
   end

   fabr_out_stage u_out (.clk(clk), .rst_n(rst_n), .d_in(nxt), .q(cur));

   assign out_valid = cur.valid;
   assign out_sof   = cur.sof;
   assign out_eof   = cur.eof;
   assign out_data  = cur.data;
endmodule

// File: rtl/fabr_checker.sv
module fabr_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_sof,
   input logic              in_eof,
   input logic [DATA_W-1:0] in_data,
   input logic              out_valid,
   input logic              out_sof,
   input logic              out_eof,
   input logic [DATA_W-1:0] out_data
);
   logic frame_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame_open <= 1'b0;
      else if (in_valid && in_sof) frame_open <= !in_eof;
      else if (in_valid && in_eof) frame_open <= 1'b0;
   end

   always_comb begin
      if (!rst_n) assert_reset_quiet_R1: assert (!out_valid && !out_sof && !out_eof);
   end

   assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_sof && !out_eof));
   assert_sof_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> out_sof);
   assert_eof_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof) |=> out_eof);
   assert_fc_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> (out_data == $past(in_data)));
   assert_kept_or_mirrored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_data == $past(in_data) ||
                    out_data == fabr_pkg::rev_byte($past(in_data))));
   assert_outside_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_sof && !frame_open) |=> (out_data == $past(in_data)));
endmodule

bind fa_addr_bitswap fabr_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
   .in_eof(in_eof), .in_data(in_data), .out_valid(out_valid),
   .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data)
);

// File: tb/fa_addr_bitswap_bench.sv
module fa_addr_bitswap_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] in_chan;
   logic [3:0] chan_swap_en;
   logic       in_valid, in_sof, in_eof;
   logic [7:0] in_data;
   logic       out_valid, out_sof, out_eof;
   logic [7:0] out_data;

   always #10 clk = ~clk;

   fa_addr_bitswap u_fa_addr_bitswap (
      .clk(clk), .rst_n(rst_n), .in_chan(in_chan), .chan_swap_en(chan_swap_en),
      .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
      .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data)
   );

   int    vectors = 0, miscompares = 0;
   bit    finished = 0;
   string cur_req = "R2";
   logic  e_valid = 0, e_sof = 0, e_eof = 0;
   logic [7:0] e_data = 0;
   bit    m_active = 0, m_long = 0, m_en = 0;
   int    m_idx = 0;
   logic [1:0] nx_chan = 0;
   logic [3:0] nx_en = 0;
   logic [7:0] seen[$];

   function automatic logic [7:0] rev8(logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction

   task automatic check_outputs();
      vectors++;
      if ({out_valid, out_sof, out_eof} !== {e_valid, e_sof, e_eof} ||
          (e_valid && out_data !== e_data)) begin
         miscompares++;
         $display("FAIL %s: got v%0b s%0b e%0b d%02h, expected v%0b s%0b e%0b d%02h",
                  cur_req, out_valid, out_sof, out_eof, out_data,
                  e_valid, e_sof, e_eof, e_data);
      end
      if (out_valid) seen.push_back(out_data);
   endtask

   task automatic drive(input bit v, input bit s, input bit e, input logic [7:0] d);
      int lim;
      @(negedge clk);
      check_outputs();
      in_valid = v; in_sof = s; in_eof = e; in_data = d;
      in_chan = nx_chan; chan_swap_en = nx_en;
      e_valid = v; e_sof = v && s; e_eof = v && e; e_data = d;
      if (v) begin
         if (s) begin
            m_active = !e; m_idx = 1; m_long = d[6]; m_en = nx_en[nx_chan];
         end else if (m_active) begin
            lim = m_long ? 12 : 4;
            if (m_en && m_idx >= 1 && m_idx <= lim) e_data = rev8(d);
            m_idx++;
            if (e) m_active = 0;
         end
      end
   endtask

   task automatic send(input logic [7:0] b[$], input int gap);
      for (int i = 0; i < b.size(); i++) begin
         if (gap > 0 && i > 0 && i % gap == 0) drive(0, 0, 0, 8'h00);
         drive(1, i == 0, i == b.size() - 1, b[i]);
      end
   endtask

   task automatic expect_byte(input int pos, input logic [7:0] exp);
      vectors++;
      if (pos >= seen.size() || seen[pos] !== exp) begin
         miscompares++;
         $display("FAIL R4: byte %0d got %02h, expected %02h", pos,
                  (pos < seen.size()) ? seen[pos] : 8'hxx, exp);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [7:0] f[$];
      rst_n = 0; in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0;
      in_chan = 0; chan_swap_en = 0;
      repeat (3) @(posedge clk);
      // R1: outputs quiet under reset
      @(negedge clk);
      vectors++;
      if ({out_valid, out_sof, out_eof, out_data} !== 11'd0) begin
         miscompares++;
         $display("FAIL R1: got %b, expected 0", {out_valid, out_sof, out_eof, out_data});
      end
      rst_n = 1;

      // R4 / R3 / R6: long addresses, fixed example
      cur_req = "R4"; nx_chan = 1; nx_en = 4'b0010;
      drive(0, 0, 0, 0);
      seen.delete();
      f = '{8'h50, 8'h08, 8'h00, 8'h17, 8'hC2, 8'hA1, 8'h03,
            8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'h01, 8'h80, 8'hF0};
      send(f, 0);
      drive(0, 0, 0, 0); drive(0, 0, 0, 0);
      expect_byte(1, 8'h10); expect_byte(2, 8'h00); expect_byte(3, 8'hE8);
      expect_byte(4, 8'h43); expect_byte(5, 8'h85); expect_byte(6, 8'hC0);

      // R5 / R6: short addresses, group bit set
      cur_req = "R5";
      f = '{8'h10, 8'h81, 8'h23, 8'h45, 8'h67, 8'h0F, 8'hAA, 8'hC3};
      send(f, 0);
      // R7: channel with enable clear
      cur_req = "R7"; nx_chan = 2;
      f = '{8'h50, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
            8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D};
      send(f, 0);
      // R8: enable and channel flipped mid-frame
      cur_req = "R8"; nx_chan = 0; nx_en = 4'b0001;
      drive(1, 1, 0, 8'h50);
      nx_en = 4'b0000; nx_chan = 3;
      for (int i = 1; i < 14; i++) drive(1, 0, i == 13, 8'(i * 17));
      nx_chan = 3; nx_en = 4'b0000;
      drive(1, 1, 0, 8'h10);
      nx_en = 4'b1111;
      for (int i = 1; i < 7; i++) drive(1, 0, i == 6, 8'(i * 29));
      // R9: gaps inside a frame and bytes outside any frame
      cur_req = "R9"; nx_chan = 1; nx_en = 4'b0010;
      drive(1, 0, 0, 8'h01); drive(1, 0, 1, 8'h70);
      f = '{8'h50, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66,
            8'h77, 8'h88, 8'h99, 8'hAB, 8'hCD, 8'hEF, 8'h3C};
      send(f, 2);
      drive(1, 0, 0, 8'h0E);
      // R10: frame cut inside addresses, then a new frame
      cur_req = "R10";
      f = '{8'h50, 8'h01, 8'h03, 8'h07}; send(f, 0);
      drive(1, 1, 1, 8'h40);
      f = '{8'h10, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10}; send(f, 0);
      // R11: start-of-frame inside an open frame
      cur_req = "R11";
      drive(1, 1, 0, 8'h50); drive(1, 0, 0, 8'h01); drive(1, 0, 0, 8'h02);
      f = '{8'h10, 8'h0C, 8'h30, 8'h03, 8'hC0, 8'h55}; send(f, 0);

      // R2 and mixed traffic
      cur_req = "R2";
      for (int k = 0; k < 40; k++) begin
         int n;
         n = $urandom_range(1, 20);
         nx_chan = 2'($urandom_range(0, 3));
         nx_en = 4'($urandom_range(0, 15));
         f.delete();
         for (int i = 0; i < n; i++) f.push_back(8'($urandom_range(0, 255)));
         send(f, $urandom_range(0, 3));
         if (k % 5 == 0) drive(0, 0, 0, 0);
      end
      drive(0, 0, 0, 0); drive(0, 0, 0, 0);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule